// File: doc/BRIEF.md
# Shared-Buffer Virtual Output Queue

This block is the receive-side store of one input port of a four-output packet switch. Each cycle it can accept one single-flit packet from a valid/ready stream. It checks the packet's even parity, places a good packet in the lowest free slot of a 16-slot shared buffer, and threads the slot onto one of eight queues. There is one queue for each pair of destination output and priority level. Flits that fail parity are consumed and thrown away.

The queues are linked lists. A table holds a head pointer, a tail pointer and a live bit for each queue, and a per-slot link table gives the successor of each stored slot. The last slot of a queue always links to itself. An enqueue onto a non-empty queue therefore writes two links in the same cycle: the old tail's link and the new slot's own link. A scheduler outside this block picks a queue with `deq_sel`. The block answers at once with `deq_avail` and the head packet on `deq_data`. Asserting `deq_take` removes that head at the next clock edge.

Back-pressure: `in_ready` is high exactly while at least one slot is free. A flit transfers when `in_valid` and `in_ready` are both high at a rising edge. A slot freed by a dequeue in the same cycle does not raise `in_ready` until the following cycle. The dequeue side is a valid/ready pair with the roles reversed: `deq_avail` acts as valid and `deq_take` as ready. A take against an empty queue does nothing.

Top module: `vlq_input_buffer`

## Requirements
- R1: A transferred flit whose 12 bits XOR to 1 is dropped. No queue changes and no slot is used.
- R2: Flit layout: bits [3:0] payload, [9:4] route, [10] priority, [11] parity. A good flit goes to queue index `{priority, route[1:0]}`, in the range 0 to 7.
- R3: `in_ready` is 1 exactly when fewer than 16 packets are stored. When `in_ready` is 0, no flit is taken, even if a dequeue happens in the same cycle.
- R4: Each queue returns its packets in arrival order. `deq_data` carries bits [9:0] of the stored flit (payload and route).
- R5: `deq_avail` is 1 exactly when the queue selected by `deq_sel` holds at least one packet. Packets in one queue never appear in another.
- R6: Bit i of `q_nonempty` is 1 exactly when queue i holds a packet. Removing the only packet of a queue clears its bit at the next edge.
- R7: An enqueue and a dequeue on the same queue in one cycle both take effect, and order is preserved. This includes the case where the queue held a single packet.
- R8: After reset, all queues are empty and `in_ready` is 1.
- R9: `deq_take` on an empty queue has no effect on any queue.
- R10: The slot for a new packet is the lowest-numbered free slot. A dequeued slot becomes free at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input ready (a slot is free) |
| in_flit | input | 12 | Input flit: parity, priority, route, payload |
| deq_sel | input | 3 | Queue index chosen by the scheduler |
| deq_take | input | 1 | Remove the head of the selected queue |
| deq_avail | output | 1 | Selected queue is non-empty |
| deq_data | output | 10 | Route and payload of the selected head packet |
| q_nonempty | output | 8 | Per-queue non-empty flags |

## Verification
The delicate overlap is an enqueue and a dequeue landing on the same queue in the same cycle. The hardest case is when that queue holds one packet: the head must move to the new slot rather than be cleared. The bench provokes this with directed steps on queues holding one and several packets. A long pseudo-random sweep then mixes takes, selections and good and bad flits. After every cycle, the bench compares the order of `deq_data`, `deq_avail`, `q_nonempty` and `in_ready` against eight reference FIFOs kept in the bench. A dequeue arriving while the buffer is full is also exercised, to confirm that the freed slot is not offered in the same cycle.

// File: rtl/vlq_pkg.sv
package vlq_pkg;
  localparam int PAY_W   = 4;
  localparam int ROUTE_W = 6;
  localparam int FLIT_W  = PAY_W + ROUTE_W + 2;
  localparam int STORE_W = PAY_W + ROUTE_W;

  typedef struct packed {
    logic               parity;
    logic               prio;
    logic [ROUTE_W-1:0] route;
    logic [PAY_W-1:0]   payload;
  } flit_t;
endpackage

// File: rtl/vlq_flit_decode.sv
module vlq_flit_decode
  import vlq_pkg::*;
#(
  parameter int DEST_BITS = 2,
  localparam int QID_W = DEST_BITS + 1
) (
  input  flit_t              flit,
  output logic               parity_ok,
  output logic [QID_W-1:0]   qid,
  output logic [STORE_W-1:0] store_word
);
  always_comb begin
    parity_ok  = ~(^flit);
    qid        = {flit.prio, flit.route[DEST_BITS-1:0]};
    store_word = {flit.route, flit.payload};
  end
endmodule

// File: rtl/vlq_free_enc.sv
module vlq_free_enc #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] occ,
  output logic [PTR_W-1:0] free_idx,
  output logic             full
);
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) free_idx = PTR_W'(i);
    end
    full = &occ;
  end
endmodule

// File: rtl/vlq_slot_store.sv
module vlq_slot_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 10,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/vlq_link_table.sv
module vlq_link_table #(
  parameter int DEPTH = 16,
  parameter int NQ    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int QID_W = $clog2(NQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enq,
  input  logic [QID_W-1:0]          enq_q,
  input  logic [PTR_W-1:0]          enq_slot,
  input  logic                      deq,
  input  logic [QID_W-1:0]          deq_q,
  output logic [NQ-1:0][PTR_W-1:0]  head,
  output logic [NQ-1:0]             live
);
  logic [NQ-1:0][PTR_W-1:0] tail;
  logic [PTR_W-1:0]         link [DEPTH];

  logic [PTR_W-1:0] old_tail;
  logic             enq_onto_live;
  logic [PTR_W-1:0] deq_head;
  logic             deq_is_last;

  always_comb begin
    old_tail      = tail[enq_q];
    enq_onto_live = live[enq_q];
    deq_head      = head[deq_q];
    deq_is_last   = (link[deq_head] == deq_head);
  end

  // Queue table: head, tail and live bit per queue.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      head <= '0;
      tail <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (deq && deq_q == QID_W'(q)) begin
          if (deq_is_last) live[q] <= 1'b0;
          else             head[q] <= link[deq_head];
        end
        if (enq && enq_q == QID_W'(q)) begin
          tail[q] <= enq_slot;
          if (!live[q] || (deq && deq_q == QID_W'(q) && deq_is_last)) begin
            head[q] <= enq_slot;
            live[q] <= 1'b1;
          end
        end
      end
    end
  end

  // Link table: the new slot links to itself; the old tail links forward.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) link[e] <= PTR_W'(e);
    end else if (enq) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (PTR_W'(e) == enq_slot)                       link[e] <= enq_slot;
        else if (enq_onto_live && PTR_W'(e) == old_tail) link[e] <= enq_slot;
      end
    end
  end
endmodule

// File: rtl/vlq_input_buffer.sv
module vlq_input_buffer
  import vlq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DEST_BITS = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int QID_W = DEST_BITS + 1,
  localparam int NQ    = 1 << QID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FLIT_W-1:0]  in_flit,
  input  logic [QID_W-1:0]   deq_sel,
  input  logic               deq_take,
  output logic               deq_avail,
  output logic [STORE_W-1:0] deq_data,
  output logic [NQ-1:0]      q_nonempty
);
  logic                     parity_ok;
  logic [QID_W-1:0]         in_qid;
  logic [STORE_W-1:0]       in_word;
  logic [DEPTH-1:0]         occ;
  logic [PTR_W-1:0]         free_idx;
  logic                     full;
  logic [NQ-1:0][PTR_W-1:0] head;
  logic [NQ-1:0]            live;
  logic                     enq, pop;
  logic [PTR_W-1:0]         pop_slot;

  vlq_flit_decode #(.DEST_BITS(DEST_BITS)) u_dec (
    .flit(flit_t'(in_flit)), .parity_ok(parity_ok), .qid(in_qid), .store_word(in_word)
  );

  vlq_free_enc #(.DEPTH(DEPTH)) u_free (
    .occ(occ), .free_idx(free_idx), .full(full)
  );

  always_comb begin
    in_ready   = !full;
    enq        = in_valid && in_ready && parity_ok;
    q_nonempty = live;
    deq_avail  = live[deq_sel];
    pop        = deq_take && deq_avail;
    pop_slot   = head[deq_sel];
  end

  vlq_link_table #(.DEPTH(DEPTH), .NQ(NQ)) u_links (
    .clk(clk), .rst_n(rst_n),
    .enq(enq), .enq_q(in_qid), .enq_slot(free_idx),
    .deq(pop), .deq_q(deq_sel),
    .head(head), .live(live)
  );

  vlq_slot_store #(.DEPTH(DEPTH), .WIDTH(STORE_W)) u_store (
    .clk(clk), .wr_en(enq), .wr_addr(free_idx), .wr_data(in_word),
    .rd_addr(pop_slot), .rd_data(deq_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (enq && free_idx == PTR_W'(e))      occ[e] <= 1'b1;
        else if (pop && pop_slot == PTR_W'(e)) occ[e] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vlq_input_buffer_chk.sv
module vlq_input_buffer_chk #(
  parameter int DEPTH     = 16,
  parameter int DEST_BITS = 2,
  localparam int QID_W = DEST_BITS + 1,
  localparam int NQ    = 1 << QID_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [11:0]      in_flit,
  input logic [QID_W-1:0] deq_sel,
  input logic             deq_take,
  input logic             deq_avail,
  input logic [NQ-1:0]    q_nonempty,
  input logic [DEPTH-1:0] occ
);
  logic             good_in, taken;
  logic [QID_W-1:0] tgt;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] qcnt [NQ];

  assign good_in = in_valid && in_ready && (^in_flit == 1'b0);
  assign taken   = deq_take && deq_avail;
  assign tgt     = {in_flit[10], in_flit[4 + DEST_BITS - 1:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      for (int q = 0; q < NQ; q++) qcnt[q] <= '0;
    end else begin
      total <= total + CNT_W'(good_in) - CNT_W'(taken);
      for (int q = 0; q < NQ; q++) begin
        qcnt[q] <= qcnt[q] + CNT_W'(good_in && tgt == QID_W'(q))
                           - CNT_W'(taken && deq_sel == QID_W'(q));
      end
    end
  end

  // R3: ready tracks free room
  a_r3_ready_vs_room: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (total < CNT_W'(DEPTH)));

  // R10: occupancy matches number stored
  a_r10_occ_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) == int'(total));

  // R1: bad parity flit allocates nothing
  a_r1_bad_parity_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ^in_flit && !taken) |=> $stable(occ));

  // R9: take on empty queue leaves occupancy alone when no flit enters
  a_r9_empty_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_take && !deq_avail && !good_in) |=> $stable(occ) && $stable(q_nonempty));

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_q
      // R6: per-queue flag tracks its own count
      a_r6_nonempty_flag: assert property (@(posedge clk) disable iff (!rst_n)
        q_nonempty[q] == (qcnt[q] != '0));
    end
  endgenerate
endmodule

bind vlq_input_buffer vlq_input_buffer_chk #(.DEPTH(DEPTH), .DEST_BITS(DEST_BITS)) u_chk (.*);

// File: tb/tb_vlq_input_buffer.sv
module tb_vlq_input_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] in_flit;
  logic [2:0]  deq_sel;
  logic        deq_take;
  logic        deq_avail;
  logic [9:0]  deq_data;
  logic [7:0]  q_nonempty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [9:0] mq [8][$];
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  vlq_input_buffer dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input logic [3:0] pay, input logic [5:0] rt,
                                     input logic pr, input logic bad);
    logic p;
    p = (^{pr, rt, pay}) ^ bad;
    return {p, pr, rt, pay};
  endfunction

  function automatic int stored();
    int n = 0;
    for (int q = 0; q < 8; q++) n += mq[q].size();
    return n;
  endfunction

  function automatic logic [7:0] exp_ne();
    logic [7:0] v;
    for (int q = 0; q < 8; q++) v[q] = (mq[q].size() != 0);
    return v;
  endfunction

  function automatic logic [31:0] nxt_rng();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  task automatic step(input logic v, input logic [11:0] f, input logic tk,
                      input logic [2:0] s, input string tag);
    bit acc, good;
    logic [2:0] q;
    @(negedge clk);
    in_valid = v; in_flit = f; deq_take = tk; deq_sel = s;
    #1;
    chk(q_nonempty == exp_ne(), {tag, " R6 q_nonempty"}, q_nonempty, exp_ne());
    chk(in_ready == (stored() < 16), {tag, " R3 in_ready"}, in_ready, stored() < 16);
    chk(deq_avail == (mq[s].size() != 0), {tag, " R5 deq_avail"}, deq_avail, mq[s].size() != 0);
    if (mq[s].size() != 0)
      chk(deq_data == mq[s][0], {tag, " R4 deq_data"}, deq_data, mq[s][0]);
    acc  = v && (stored() < 16);
    good = (^f == 1'b0);
    q    = {f[10], f[5:4]};
    @(posedge clk);
    if (tk && mq[s].size() != 0) void'(mq[s].pop_front());
    if (acc && good) mq[q].push_back(f[9:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_flit = '0; deq_take = 0; deq_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R8 ready after reset", in_ready, 1);
    chk(q_nonempty == 8'h00, "R8 empty after reset", q_nonempty, 0);

    // R2, R4: two flits into every queue, varied upper route bits
    for (int i = 0; i < 16; i++)
      step(1, mk(4'(i), {4'(i * 3), 2'(i % 4)}, 1'((i / 4) % 2), 0), 0, 0, "R2");
    for (int q = 0; q < 8; q++) begin
      step(0, '0, 1, 3'(q), "R4");
      step(0, '0, 1, 3'(q), "R4");
    end
    step(0, '0, 0, 0, "R4");

    // R1: bad parity flits on every queue are dropped
    for (int q = 0; q < 8; q++)
      step(1, mk(4'hA, {4'h5, 2'(q % 4)}, 1'(q / 4), 1), 0, 3'(q), "R1");
    step(0, '0, 0, 0, "R1");

    // R3, R10: fill all 16 slots, push while full, then a dequeue during full
    for (int i = 0; i < 16; i++)
      step(1, mk(4'(15 - i), {4'h0, 2'(i % 4)}, 1'(i % 2), 0), 0, 0, "R3");
    step(1, mk(4'h7, 6'h0, 0, 0), 0, 0, "R3 full");
    step(1, mk(4'h8, 6'h0, 0, 0), 1, 0, "R3 full+deq");
    step(1, mk(4'h9, 6'h1, 1, 0), 0, 5, "R10 reuse");
    for (int q = 0; q < 8; q++)
      while (mq[q].size() != 0) step(0, '0, 1, 3'(q), "R10 drain");

    // R7: enqueue + dequeue same queue, single packet and several packets
    step(1, mk(4'h1, 6'h03, 0, 0), 0, 3, "R7");
    step(1, mk(4'h2, 6'h03, 0, 0), 1, 3, "R7 single");
    step(0, '0, 0, 3, "R7 single");
    step(1, mk(4'h3, 6'h03, 0, 0), 0, 3, "R7");
    step(1, mk(4'h4, 6'h03, 0, 0), 1, 3, "R7 multi");
    step(1, mk(4'h5, 6'h03, 0, 0), 1, 3, "R7 multi");
    step(1, mk(4'h6, 6'h02, 1, 0), 1, 3, "R7 other q");
    for (int k = 0; k < 4; k++) step(0, '0, 1, 3, "R7 drain");
    step(0, '0, 1, 6, "R7 drain");

    // R9: take on empty queues
    step(1, mk(4'hC, 6'h01, 1, 0), 0, 5, "R9");
    for (int q = 0; q < 8; q++)
      if (q != 5) step(0, '0, 1, 3'(q), "R9 empty take");
    step(0, '0, 1, 5, "R9");

    // Mixed sweep
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = nxt_rng();
      step(r[0] | r[1], mk(r[5:2], r[11:6], r[12], r[15:13] == 3'b000),
           r[16] & r[17], r[20:18], "R7 sweep");
    end
    for (int q = 0; q < 8; q++)
      while (mq[q].size() != 0) step(0, '0, 1, 3'(q), "R4 final");
    step(0, '0, 0, 0, "R6 final");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule